// File: doc/BRIEF.md
# SDRAM Refresh and Power-State Manager

This block keeps an SDRAM device refreshed and moves it in and out of its clock-enable based low-power states. A free-running interval counter produces one refresh demand per refresh period. Demands are queued in a small saturating counter. Whenever the command sequencer reports that every bank is idle, the block closes all rows with a precharge-all command and then issues an auto-refresh command.

The block also serves two level-sensitive host requests. While `selfref_req` is high, the device is held in self-refresh, which is entered by an auto-refresh code issued in the same cycle that the clock enable falls. While `pwrdn_req` is high, the device is held in power-down, which is entered by dropping the clock enable under a no-operation command. The block drives the clock enable and a four-bit command code into the command multiplexer. It tells the host through `busy` when the bus belongs to it.

Top module: `sdram_rfpm`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cke` is 1, `cmd_n` is the no-operation code 4'b0111 ({cs_n, ras_n, cas_n, we_n}), `a10` is 0 and `busy` is 0.
- R2: With banks idle and no power request, auto-refresh commands (cke 1, `cmd_n` 4'b0001) are spaced exactly REF_INTERVAL clocks apart. The default is 1560 clocks, which is 15.6 us at 100 MHz and gives 4096 refreshes per 64 ms.
- R3: Each auto-refresh is preceded by a precharge-all (`cmd_n` 4'b0010 with `a10` 1) exactly TRP_CYC clocks earlier. The cycles between them carry no-operation.
- R4: After an auto-refresh, the next TRC_CYC-1 cycles carry no-operation and `busy` stays high. If nothing is pending, `busy` is low TRC_CYC cycles after the refresh.
- R5: No precharge-all is issued while `banks_idle` is low. `busy` is high whenever a refresh is pending.
- R6: Pending refreshes saturate at MAX_PEND. Once the banks become idle, the backlog is drained in back-to-back sequences of TRC_CYC+TRP_CYC+1 cycles each.
- R7: A pending refresh takes priority over power-down. Power-down is not entered while one is pending, and a refresh that falls due during power-down forces an exit followed by a precharge-all two cycles after `cke` rises.
- R8: Power-down entry drops `cke` with no-operation one cycle after `pwrdn_req` is seen. Entry is allowed with rows open but refused while `burst_active` is high. Exit raises `cke` with no-operation.
- R9: Self-refresh entry requires `banks_idle`. In the entry cycle `cke` is 0 with `cmd_n` 4'b0001 while `cke` was 1 in the cycle before. While the request is held, `cke` stays 0 with no-operation. Self-refresh wins over power-down when both are requested.
- R10: On self-refresh exit, `cke` rises with no-operation, and no-operation is held for SRX_CYC cycles before the block returns to idle with `busy` low. The exit also clears pending refreshes and restarts the refresh interval.
- R11: `busy` is high in every cycle the block is in a power-down or self-refresh state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| banks_idle | input | 1 | All banks precharged and idle, from the command sequencer |
| burst_active | input | 1 | A read or write burst is in progress |
| selfref_req | input | 1 | Hold the device in self-refresh while high |
| pwrdn_req | input | 1 | Hold the device in power-down while high |
| cke | output | 1 | Clock enable to the device |
| cmd_n | output | 4 | Command code {cs_n, ras_n, cas_n, we_n} to the command mux |
| a10 | output | 1 | Address bit 10, high to select all banks for precharge |
| busy | output | 1 | Block owns the command bus or a refresh is pending |

## Verification
The bench first exercises a set of power-request combinations. A design that entered power-down during a burst, or entered self-refresh with rows open, would show `cke` low where it must stay high. It then holds the banks busy across several refresh periods. A counter that wrapped instead of saturating would drain too few refreshes, and a missing interlock would show a precharge while rows are open. It also raises a power-down request while a refresh is pending and lets a refresh fall due inside power-down. A design with the wrong priority would drop `cke` early or never leave power-down. Finally, after self-refresh exit it checks the no-operation exit window and that no refresh follows at once. A design that kept stale demands would precharge straight after the exit.

// File: rtl/rfpm_pkg.sv
package rfpm_pkg;

    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PREA,
        ST_WAIT_RP,
        ST_AREF,
        ST_WAIT_RC,
        ST_SR_IN,
        ST_SR_HOLD,
        ST_SR_OUT,
        ST_PD_HOLD,
        ST_PD_OUT
    } rf_state_e;

    typedef struct packed {
        logic       cke;
        logic [3:0] cmd;
        logic       a10;
    } bus_drv_t;

    function automatic bus_drv_t drive_of(rf_state_e s);
        bus_drv_t d;
        d.cke = 1'b1;
        d.cmd = CMD_NOP;
        d.a10 = 1'b0;
        case (s)
            ST_PREA: begin
                d.cmd = CMD_PRE;
                d.a10 = 1'b1;
            end
            ST_AREF:    d.cmd = CMD_REF;
            ST_SR_IN: begin
                d.cke = 1'b0;
                d.cmd = CMD_REF;
            end
            ST_SR_HOLD: d.cke = 1'b0;
            ST_PD_HOLD: d.cke = 1'b0;
            default:    ;
        endcase
        return d;
    endfunction

    function automatic logic in_self_ref(rf_state_e s);
        return (s == ST_SR_IN) || (s == ST_SR_HOLD) || (s == ST_SR_OUT);
    endfunction

endpackage

// File: rtl/rfpm_tick.sv
module rfpm_tick #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST) && !clr;
endmodule

// File: rtl/rfpm_pend.sv
module rfpm_pend #(
    parameter int MAX_PEND = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    input  logic dec,
    output logic has_pend
);
    localparam int PW = $clog2(MAX_PEND + 1);
    localparam logic [PW-1:0] TOP = PW'(MAX_PEND);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && !dec && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end else if (dec && !inc && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign has_pend = (cnt != '0);
endmodule

// File: rtl/rfpm_fsm.sv
module rfpm_fsm
    import rfpm_pkg::*;
#(
    parameter int TRP_CYC = 3,
    parameter int TRC_CYC = 6,
    parameter int SRX_CYC = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      has_pend,
    input  logic      banks_idle,
    input  logic      burst_active,
    input  logic      selfref_req,
    input  logic      pwrdn_req,
    output rf_state_e st
);
    localparam int MAXA = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
    localparam int MAXT = (MAXA > SRX_CYC) ? MAXA : SRX_CYC;
    localparam int TW   = $clog2(MAXT + 1);

    rf_state_e st_nx;
    logic [TW-1:0] tmr, tmr_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            tmr <= '0;
        end else begin
            st  <= st_nx;
            tmr <= tmr_nx;
        end
    end

    always_comb begin
        st_nx  = st;
        tmr_nx = tmr;
        case (st)
            ST_IDLE: begin
                if (has_pend) begin
                    if (banks_idle) st_nx = ST_PREA;
                end else if (selfref_req && banks_idle) begin
                    st_nx = ST_SR_IN;
                end else if (pwrdn_req && !burst_active) begin
                    st_nx = ST_PD_HOLD;
                end
            end
            ST_PREA: begin
                st_nx  = ST_WAIT_RP;
                tmr_nx = TW'(TRP_CYC - 2);
            end
            ST_WAIT_RP: begin
                if (tmr == '0) st_nx = ST_AREF;
                else           tmr_nx = tmr - 1'b1;
            end
            ST_AREF: begin
                st_nx  = ST_WAIT_RC;
                tmr_nx = TW'(TRC_CYC - 2);
            end
            ST_WAIT_RC: begin
                if (tmr == '0) st_nx = ST_IDLE;
                else           tmr_nx = tmr - 1'b1;
            end
            ST_SR_IN:   st_nx = ST_SR_HOLD;
            ST_SR_HOLD: begin
                if (!selfref_req) begin
                    st_nx  = ST_SR_OUT;
                    tmr_nx = TW'(SRX_CYC - 1);
                end
            end
            ST_SR_OUT: begin
                if (tmr == '0) st_nx = ST_IDLE;
                else           tmr_nx = tmr - 1'b1;
            end
            ST_PD_HOLD: begin
                if (has_pend || !pwrdn_req) st_nx = ST_PD_OUT;
            end
            ST_PD_OUT:  st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/sdram_rfpm.sv
module sdram_rfpm
    import rfpm_pkg::*;
#(
    parameter int REF_INTERVAL = 1560,
    parameter int MAX_PEND     = 4,
    parameter int TRP_CYC      = 3,
    parameter int TRC_CYC      = 6,
    parameter int SRX_CYC      = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       banks_idle,
    input  logic       burst_active,
    input  logic       selfref_req,
    input  logic       pwrdn_req,
    output logic       cke,
    output logic [3:0] cmd_n,
    output logic       a10,
    output logic       busy
);
    rf_state_e st;
    bus_drv_t  drv;
    logic      tick, has_pend, in_sr;

    assign in_sr = in_self_ref(st);

    rfpm_tick #(.INTERVAL(REF_INTERVAL)) u_tick (
        .clk (clk),
        .rst (rst),
        .clr (in_sr),
        .tick(tick)
    );

    rfpm_pend #(.MAX_PEND(MAX_PEND)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .clr     (in_sr),
        .inc     (tick),
        .dec     (st == ST_AREF),
        .has_pend(has_pend)
    );

    rfpm_fsm #(
        .TRP_CYC(TRP_CYC),
        .TRC_CYC(TRC_CYC),
        .SRX_CYC(SRX_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .has_pend    (has_pend),
        .banks_idle  (banks_idle),
        .burst_active(burst_active),
        .selfref_req (selfref_req),
        .pwrdn_req   (pwrdn_req),
        .st          (st)
    );

    assign drv   = drive_of(st);
    assign cke   = drv.cke;
    assign cmd_n = drv.cmd;
    assign a10   = drv.a10;
    assign busy  = (st != ST_IDLE) || has_pend;
endmodule

// File: rtl/rfpm_chk.sv
module rfpm_chk #(
    parameter int TRP_CYC = 3,
    parameter int TRC_CYC = 6
) (
    input logic       clk,
    input logic       rst,
    input logic       banks_idle,
    input logic       burst_active,
    input logic       cke,
    input logic [3:0] cmd_n,
    input logic       a10,
    input logic       busy
);
    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;
    localparam int SW = $clog2(TRP_CYC + 2);
    localparam int RW = $clog2(TRC_CYC + 1);
    localparam logic [SW-1:0] SAT = SW'(TRP_CYC + 1);

    logic [SW-1:0] since_pre;
    logic [RW-1:0] rc_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_pre <= SAT;
            rc_left   <= '0;
        end else begin
            if (cmd_n == PRE)       since_pre <= SW'(1);
            else if (since_pre != SAT) since_pre <= since_pre + 1'b1;
            if (cke && cmd_n == REF) rc_left <= RW'(TRC_CYC - 1);
            else if (rc_left != '0)  rc_left <= rc_left - 1'b1;
        end
    end

    p_pre_all_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_n == PRE) |-> (a10 && $past(banks_idle)));

    p_ref_after_pre_r3: assert property (@(posedge clk) disable iff (rst)
        (cke && cmd_n == REF) |-> (since_pre == SW'(TRP_CYC)));

    p_rc_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (rc_left != '0) |-> (cmd_n == NOP && busy));

    p_pd_no_burst_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(cke) && cmd_n == NOP) |-> !$past(burst_active));

    p_cke_low_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!cke && !$past(cke)) |-> (cmd_n == NOP));

    p_sr_entry_r9: assert property (@(posedge clk) disable iff (rst)
        (!cke && cmd_n == REF) |-> ($past(cke) && $past(banks_idle)));

    p_cke_rise_nop_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> (cmd_n == NOP));

    p_low_power_busy_r11: assert property (@(posedge clk) disable iff (rst)
        !cke |-> busy);
endmodule

bind sdram_rfpm rfpm_chk #(
    .TRP_CYC(TRP_CYC),
    .TRC_CYC(TRC_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .banks_idle  (banks_idle),
    .burst_active(burst_active),
    .cke         (cke),
    .cmd_n       (cmd_n),
    .a10         (a10),
    .busy        (busy)
);

// File: tb/sdram_rfpm_tb.sv
module sdram_rfpm_tb;
    localparam int CLK_PERIOD = 10;
    localparam int INTERVAL   = 20;
    localparam int NPEND      = 3;
    localparam int TRP        = 3;
    localparam int TRC        = 6;
    localparam int SRX        = 2;
    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic banks_idle = 1'b1, burst_active = 1'b0, selfref_req = 1'b0, pwrdn_req = 1'b0;
    logic cke, a10, busy;
    logic [3:0] cmd_n;
    int cyc = 0;
    int n_run = 0, n_fail = 0;

    // {idle, burst, pwrdn, selfref, expected cke, expected busy}
    localparam logic [5:0] VEC [6] = '{
        6'b101001,  // R8: power-down with banks idle
        6'b111010,  // R8: refused during burst
        6'b001001,  // R8: power-down with rows open
        6'b100101,  // R9: self-refresh with banks idle
        6'b000110,  // R9: self-refresh refused with rows open
        6'b101101   // R9: self-refresh wins, still low power
    };

    sdram_rfpm #(
        .REF_INTERVAL(INTERVAL), .MAX_PEND(NPEND),
        .TRP_CYC(TRP), .TRC_CYC(TRC), .SRX_CYC(SRX)
    ) u_dut (
        .clk(clk), .rst(rst), .banks_idle(banks_idle), .burst_active(burst_active),
        .selfref_req(selfref_req), .pwrdn_req(pwrdn_req),
        .cke(cke), .cmd_n(cmd_n), .a10(a10), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_ref(output int at);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(cke && cmd_n == REF) && n < 200);
        at = cyc;
        if (n >= 200) check(1'b0, "R2", "refresh never issued", 0, 1);
    endtask

    task automatic wait_busy(input logic val);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (busy != val && n < 200);
        if (n >= 200) check(1'b0, "R5", "busy wait timed out", busy, val);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int t1, t2, cnt;
        bit bad;
        repeat (3) @(negedge clk);
        check(cke == 1'b1 && cmd_n == NOP && a10 == 1'b0 && busy == 1'b0,
              "R1", "outputs in reset", {cke, cmd_n, a10, busy}, 7'b1011100);
        rst = 1'b0;
        @(negedge clk);
        check(cke == 1'b1 && cmd_n == NOP && busy == 1'b0,
              "R1", "outputs after reset", {cke, cmd_n, busy}, 6'b101110);

        // R3: precharge-all, then refresh TRP clocks later
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (cmd_n != PRE && cnt < 200);
        check(a10 == 1'b1, "R3", "a10 on precharge-all", a10, 1);
        bad = 1'b0;
        for (int k = 1; k < TRP; k++) begin
            @(negedge clk);
            if (cmd_n != NOP) bad = 1'b1;
        end
        check(!bad, "R3", "gap before refresh not NOP", bad, 0);
        @(negedge clk);
        check(cke && cmd_n == REF, "R3", "refresh TRP after precharge", cmd_n, REF);
        t1 = cyc;
        // R4: quiet window after refresh
        bad = 1'b0;
        for (int k = 1; k < TRC; k++) begin
            @(negedge clk);
            if (cmd_n != NOP || !busy) bad = 1'b1;
        end
        check(!bad, "R4", "row cycle window not quiet/busy", bad, 0);
        @(negedge clk);
        check(busy == 1'b0, "R4", "busy after row cycle", busy, 0);

        // R2: spacing of refreshes
        wait_ref(t2);
        check(t2 - t1 == INTERVAL, "R2", "refresh spacing", t2 - t1, INTERVAL);

        // Vector table of power requests, each started just after a refresh
        foreach (VEC[i]) begin
            wait_ref(t1);
            repeat (TRC) @(negedge clk);
            {banks_idle, burst_active, pwrdn_req, selfref_req} = VEC[i][5:2];
            repeat (2) @(negedge clk);
            check(cke == VEC[i][1], (VEC[i][0] || !VEC[i][1]) ? "R8/R9" : "R8/R9",
                  $sformatf("vector %0d cke", i), cke, VEC[i][1]);
            check(busy == VEC[i][0], "R11", $sformatf("vector %0d busy", i), busy, VEC[i][0]);
            {banks_idle, burst_active, pwrdn_req, selfref_req} = 4'b1000;
            repeat (5) @(negedge clk);
        end

        // R5 and R6: rows held open over several intervals
        wait_ref(t1);
        repeat (TRC) @(negedge clk);
        banks_idle = 1'b0;
        bad = 1'b0;
        for (int k = 0; k < 5 * INTERVAL; k++) begin
            @(negedge clk);
            if (cmd_n == PRE) bad = 1'b1;
        end
        check(!bad, "R5", "precharge while rows open", bad, 0);
        check(busy == 1'b1, "R5", "busy while refresh pending", busy, 1);
        banks_idle = 1'b1;
        cnt = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (cke && cmd_n == REF) cnt++;
        end
        check(cnt == NPEND, "R6", "backlog drained", cnt, NPEND);

        // R7: pending refresh beats power-down
        wait_busy(1'b0);
        banks_idle = 1'b0;
        wait_busy(1'b1);
        pwrdn_req = 1'b1;
        bad = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (!cke) bad = 1'b1;
        end
        check(!bad, "R7", "power-down entered with refresh pending", bad, 0);
        banks_idle = 1'b1;
        wait_busy(1'b0);
        repeat (2) @(negedge clk);
        check(cke == 1'b0, "R7", "power-down after refresh", cke, 0);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!cke && cnt < 200);
        check(cmd_n == NOP, "R8", "power-down exit command", cmd_n, NOP);
        repeat (2) @(negedge clk);
        check(cmd_n == PRE, "R7", "forced exit then precharge", cmd_n, PRE);
        pwrdn_req = 1'b0;

        // R9 and R10: self-refresh entry, hold and exit
        wait_ref(t1);
        repeat (TRC) @(negedge clk);
        check(cke == 1'b1, "R9", "cke before entry", cke, 1);
        selfref_req = 1'b1;
        @(negedge clk);
        check(cke == 1'b0 && cmd_n == REF, "R9", "entry code", {cke, cmd_n}, {1'b0, REF});
        bad = 1'b0;
        for (int k = 0; k < 3 * INTERVAL; k++) begin
            @(negedge clk);
            if (cke || cmd_n != NOP || !busy) bad = 1'b1;
        end
        check(!bad, "R9", "self-refresh hold", bad, 0);
        selfref_req = 1'b0;
        @(negedge clk);
        check(cke == 1'b1 && cmd_n == NOP, "R10", "exit raises cke with NOP",
              {cke, cmd_n}, {1'b1, NOP});
        bad = 1'b0;
        for (int k = 1; k < SRX; k++) begin
            @(negedge clk);
            if (cmd_n != NOP || !busy) bad = 1'b1;
        end
        check(!bad, "R10", "exit window", bad, 0);
        @(negedge clk);
        check(busy == 1'b0, "R10", "idle after exit, pending cleared", busy, 0);
        bad = 1'b0;
        for (int k = 0; k < INTERVAL - 2; k++) begin
            @(negedge clk);
            if (cmd_n != NOP) bad = 1'b1;
        end
        check(!bad, "R10", "interval restarted after exit", bad, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule